// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Deserializer

This block is the receive half of a two-data-line serial NOR flash read. Once the command and address have been shifted out by other logic, a pulse on `start` with a byte count opens one read burst. The block lowers chip select and toggles the serial clock at half the system clock rate. On each rising serial-clock edge it takes one bit pair from the two data lines, and it packs the bytes it assembles into 32-bit words. When the last pair is in, it raises chip select and pulses `done`.

Boards sometimes route the two flash data lines to the opposite input pins. The `lane_swap` input exchanges the two physical lanes before any bit is assembled, so such a board still yields bytes in their natural bit order. A second assembly path, selected with `split_mode`, shifts each lane into its own 16-bit register and interleaves the two registers into the output word. It produces the same words as the byte path.

Words leave on a valid-only stream: `word_valid` pulses for one cycle with `word`. There is no ready input and no back-pressure. The serial clock cannot be stalled mid-burst, so the consumer must take every word in the cycle it is offered.

Top module: `dspi_rd_deser`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `done`, `busy` and `word_valid` are 0.
- R2: During a burst, `sclk` toggles on every system clock cycle, so it runs at half the system clock. A burst of N bytes shows exactly 4·N rising edges of `sclk`.
- R3: Each rising `sclk` edge samples one bit pair. With `lane_swap`=0, `io1` is the odd bit and `io0` the even bit. Within a byte the pairs arrive most significant first: (b7,b6), (b5,b4), (b3,b2), (b1,b0).
- R4: With `lane_swap`=1, `io0` is taken as the odd bit and `io1` as the even bit. A board with reversed lane wiring then delivers every byte in natural bit order.
- R5: A reversed board with `lane_swap`=0 delivers each byte with adjacent bit pairs exchanged (bit 2k and bit 2k+1 trade places). The same holds for a straight board with `lane_swap`=1.
- R6: Words are little-endian: the first byte received occupies bits 7:0. A full word is emitted after every 16 pairs, and `word_valid` is a single-cycle pulse.
- R7: When N is not a multiple of four, the final partial word is still emitted, with its unreceived upper bytes set to zero. N bytes give ceil(N/4) words.
- R8: With `split_mode`=1, each lane shifts into its own 16-bit register and the two are interleaved into the word. The result equals the `split_mode`=0 result for every byte count and lane setting.
- R9: `cs_n` stays low from the burst's first cycle until after the last pair is sampled. It rises in the same cycle as the one-cycle `done` pulse.
- R10: A `start` while a burst is running has no effect on that burst's length or data. A `start` with a byte count of zero opens no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst request, taken only when idle |
| byte_count | input | CNT_W | Number of bytes in the burst |
| lane_swap | input | 1 | Exchange the two physical data lanes |
| split_mode | input | 1 | Use the per-lane register assembly path |
| io0 | input | 1 | Flash data line 0 |
| io1 | input | 1 | Flash data line 1 |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| word | output | 32 | Assembled data word |
| word_valid | output | 1 | One-cycle strobe qualifying `word` |

## Verification
The bench builds the block with `CNT_W` = 4, which limits bursts to 15 bytes. It sweeps burst lengths 1 through 9 across straight and reversed board wiring, both `lane_swap` settings and both assembly paths. Those lengths cover one to three words and every remainder of a partial last word. Every burst also receives a stray start request mid-flight. Each length is therefore seen with pair-swapped and natural bytes, full and zero-filled words, and in both assembly paths.

// File: rtl/dspi_pkg.sv
`timescale 1ns/1ps
package dspi_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

  localparam int WORD_W    = 32;
  localparam int LANE_W    = WORD_W / 2;
  localparam int PAIR_IDXW = $clog2(LANE_W);

  // Interleave two lane registers (oldest pair in the MSB) into a
  // little-endian word with MSB-first pairs inside each byte.
  function automatic logic [WORD_W-1:0] merge_lanes(input logic [LANE_W-1:0] odd_l,
                                                    input logic [LANE_W-1:0] even_l);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < LANE_W; k++) begin
      w[8*(k/4) + 7 - 2*(k%4)] = odd_l[LANE_W-1-k];
      w[8*(k/4) + 6 - 2*(k%4)] = even_l[LANE_W-1-k];
    end
    return w;
  endfunction
endpackage

// File: rtl/dspi_seq.sv
`timescale 1ns/1ps
module dspi_seq
  import dspi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             sample,
  output logic             last_pair
);
  localparam int PAIR_W = CNT_W + 2;

  seq_state_t        state;
  logic [PAIR_W-1:0] pairs_left;

  always_comb begin
    accept    = (state == SEQ_IDLE) && start && (byte_count != '0);
    busy      = (state == SEQ_RUN);
    sample    = busy && !sclk;
    last_pair = sample && (pairs_left == PAIR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      done       <= 1'b0;
      pairs_left <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (accept) begin
          state      <= SEQ_RUN;
          cs_n       <= 1'b0;
          sclk       <= 1'b0;
          pairs_left <= {byte_count, 2'b00};
        end
        SEQ_RUN: if (!sclk) begin
          sclk       <= 1'b1;
          pairs_left <= pairs_left - PAIR_W'(1);
        end else begin
          sclk <= 1'b0;
          if (pairs_left == '0) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);                                                   // R1
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (sclk != $past(sclk)));                  // R2
  AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);                                             // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R9
endmodule

// File: rtl/dspi_deser.sv
`timescale 1ns/1ps
module dspi_deser
  import dspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              last_pair,
  input  logic              lane_swap,
  input  logic              split_mode,
  input  logic              io0,
  input  logic              io1,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic                 bit_odd, bit_even;
  logic [PAIR_IDXW-1:0] pcnt;
  logic [5:0]           byte_sh;
  logic [WORD_W-1:0]    acc, acc_nx, split_word;
  logic [LANE_W-1:0]    lane_odd, lane_even, lane_odd_nx, lane_even_nx;
  logic [7:0]           byte_nx;
  logic                 word_end;

  always_comb begin
    bit_odd      = lane_swap ? io0 : io1;
    bit_even     = lane_swap ? io1 : io0;
    byte_nx      = {byte_sh, bit_odd, bit_even};
    acc_nx       = acc;
    if (pcnt[1:0] == 2'd3)
      acc_nx[8*pcnt[PAIR_IDXW-1:2] +: 8] = byte_nx;
    lane_odd_nx  = {lane_odd[LANE_W-2:0], bit_odd};
    lane_even_nx = {lane_even[LANE_W-2:0], bit_even};
    split_word   = merge_lanes(lane_odd_nx  << (LANE_W-1-int'(pcnt)),
                               lane_even_nx << (LANE_W-1-int'(pcnt)));
    word_end     = (pcnt == PAIR_IDXW'(LANE_W-1)) || last_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; byte_sh <= '0; acc <= '0;
      lane_odd <= '0; lane_even <= '0;
      word <= '0; word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (clear) begin
        pcnt <= '0; byte_sh <= '0; acc <= '0;
        lane_odd <= '0; lane_even <= '0;
      end else if (sample) begin
        if (word_end) begin
          word       <= split_mode ? split_word : acc_nx;
          word_valid <= 1'b1;
          pcnt <= '0; byte_sh <= '0; acc <= '0;
          lane_odd <= '0; lane_even <= '0;
        end else begin
          pcnt      <= pcnt + 1'b1;
          byte_sh   <= byte_nx[5:0];
          acc       <= acc_nx;
          lane_odd  <= lane_odd_nx;
          lane_even <= lane_even_nx;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);                                       // R6
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(sample));                                     // R6
endmodule

// File: rtl/dspi_rd_deser.sv
`timescale 1ns/1ps
module dspi_rd_deser
  import dspi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             lane_swap,
  input  logic             split_mode,
  input  logic             io0,
  input  logic             io1,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic [31:0]      word,
  output logic             word_valid
);
  logic accept, sample, last_pair;

  dspi_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
    .accept(accept), .sample(sample), .last_pair(last_pair)
  );

  dspi_deser u_deser (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample),
    .last_pair(last_pair), .lane_swap(lane_swap), .split_mode(split_mode),
    .io0(io0), .io1(io1), .word(word), .word_valid(word_valid)
  );

  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);                                                   // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));                               // R10
endmodule

// File: tb/tb_dspi_rd_deser.sv
`timescale 1ns/1ps
module tb_dspi_rd_deser;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, lane_swap = 1'b0, split_mode = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic io0, io1, sclk, cs_n, busy, done, word_valid;
  logic [31:0] word;

  int n_checks = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dspi_rd_deser #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .lane_swap(lane_swap), .split_mode(split_mode), .io0(io0), .io1(io1),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
    .word(word), .word_valid(word_valid)
  );

  // Flash model: presents pair 0 when selected, advances after each falling sclk.
  logic [7:0] fmem [16];
  logic [5:0] pidx = '0;
  logic       fl_prev = 1'b0, wire_rev = 1'b0;
  logic [7:0] fb;
  logic       f_odd, f_even;
  always_comb begin
    fb     = fmem[pidx[5:2]];
    f_odd  = fb[7 - 2*int'(pidx[1:0])];
    f_even = fb[6 - 2*int'(pidx[1:0])];
    io0    = wire_rev ? f_odd  : f_even;
    io1    = wire_rev ? f_even : f_odd;
  end
  always @(negedge clk) begin
    if (cs_n) pidx <= '0;
    else if (fl_prev && !sclk) pidx <= pidx + 1'b1;
    fl_prev <= sclk;
  end

  // Monitor
  logic [31:0] got [8];
  int nw = 0, edges = 0, dones = 0, cs_glitch = 0, vv_err = 0;
  logic m_prev = 1'b0, m_vprev = 1'b0, cs_was_low = 1'b0;
  always @(negedge clk) begin
    if (word_valid) begin
      if (nw < 8) got[nw] = word;
      nw++;
    end
    if (word_valid && m_vprev) vv_err++;
    if (sclk && !m_prev) edges++;
    if (done) dones++;
    if (cs_n && cs_was_low && !done && dones == 0) cs_glitch++;
    if (!cs_n) cs_was_low = 1'b1;
    m_prev  = sclk;
    m_vprev = word_valid;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pswap(input logic [7:0] x);
    return ((x & 8'hAA) >> 1) | ((x & 8'h55) << 1);
  endfunction

  function automatic logic [31:0] exp_word(input int w, input int n, input bit rev, input bit sw);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      int idx = 4*w + b;
      if (idx < n) r[8*b +: 8] = (rev ^ sw) ? pswap(fmem[idx]) : fmem[idx];
    end
    return r;
  endfunction

  task automatic run_burst(input int n, input bit rev, input bit sw, input bit sp, input int seed);
    int guard = 0;
    string tag;
    for (int i = 0; i < 16; i++) fmem[i] = 8'(i*73 + seed*29 + 27);
    wire_rev = rev;
    @(negedge clk);
    nw = 0; edges = 0; dones = 0; cs_glitch = 0; vv_err = 0; cs_was_low = 1'b0;
    byte_count = CNT_W'(n); lane_swap = sw; split_mode = sp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    byte_count = CNT_W'(n + 2); start = 1'b1;   // stray request mid-burst
    @(negedge clk); start = 1'b0;
    while (dones == 0 && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(edges == 4*n, "R2 sclk rising edges / R10 stray start", edges, 4*n);
    check(nw == (n+3)/4, "R6 R7 word count", nw, (n+3)/4);
    check(vv_err == 0, "R6 valid pulse width", vv_err, 0);
    check(dones == 1 && cs_glitch == 0 && cs_n, "R9 cs_n and done", cs_glitch, 0);
    if (sp) tag = "R8 split-lane word";
    else if (rev && sw) tag = "R4 swapped lanes natural order";
    else if (rev ^ sw) tag = "R5 pair-exchanged bytes";
    else tag = "R3 straight bit order";
    for (int w = 0; w < (n+3)/4 && w < nw && w < 8; w++) begin
      logic [31:0] e = exp_word(w, n, rev, sw);
      check(got[w] == e, (4*w+4 > n) ? {tag, " R7 partial"} : tag, got[w], e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && !done && !busy && !word_valid,
          "R1 reset state", {cs_n, sclk, done, busy, word_valid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: zero byte count opens no burst
    dones = 0; edges = 0;
    byte_count = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check(cs_n && !busy && dones == 0 && edges == 0, "R10 zero count ignored", edges, 0);
    for (int n = 1; n <= 9; n++)
      for (int cfg = 0; cfg < 8; cfg++)
        run_burst(n, cfg[0], cfg[1], cfg[2], n*8 + cfg);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule